// File: doc/BRIEF.md
# Taint-Gated Sequence Controller

This block is the control unit of a small compute accelerator that also enforces an information-flow security policy. After a start pulse it walks a fixed sequence of steps. It issues two operand fetches. It then branches twice on a comparison result from the datapath, pulses the matching arithmetic controls, issues a result store and signals completion. Every comparison result arrives with a taint bit. Every memory request is accompanied by a per-bit address taint vector.

A policy register chooses how those tags are judged. A branch can be flagged whenever its condition is tainted, or only when that branch step is marked critical. A memory request can be blocked on any tainted address bit (strict protection) or only when the taint reaches the upper guard bits of the address (permissive protection). A memory step marked benign is never blocked. The checks are made locally in each step, but all of them feed one violation handler. On a violation the blocked request is suppressed, the machine parks in a halt step until reset, a security interrupt separate from the done pulse is raised, and the step and cause of the first violation are latched for software.

The steps are IDLE (0), FETCH_A (1, memory slot 0), FETCH_B (2, slot 1), TEST0 (3, branch 0), ADD (4), SUB (5), TEST1 (6, branch 1), ADJUST (7), STORE (8, slot 2, write), DONE (9) and HALT (10). The transitions are as follows:
- IDLE goes to FETCH_A on start.
- FETCH_A goes to FETCH_B, and FETCH_B goes to TEST0.
- TEST0 goes to ADD when the comparison is true and to SUB otherwise.
- ADD and SUB both go to TEST1.
- TEST1 goes to STORE when the comparison is true and to ADJUST otherwise.
- ADJUST goes to STORE.
- STORE goes to DONE, and DONE goes to IDLE.
- Any step whose check fails goes to HALT, and HALT stays in HALT.

Top module: `taint_guard_ctrl`

## Requirements
- R1: After reset all outputs are low, the step is IDLE and the policy register holds strict protection with all-branch checking (cfg bit0=1, bit1=1, bits 6:2 zero).
- R2: A run issues in order: a read on slot 0, a read on slot 1, then alu_add when cmp_result is 1 or alu_sub when 0, then alu_adj only when cmp_result is 0 at TEST1, then a write (mem_we=1) on slot 2. Each of these takes one cycle; TEST0 and TEST1 produce no output.
- R3: The step after the store pulses done for one cycle and the machine returns to IDLE; a clean run leaves sec_irq, halted and viol_valid low.
- R4: With cfg bit1=1, a tainted condition at either branch step is a violation; with cfg bit1=0, it is a violation only at a branch whose critical bit is set (cfg bit2 for TEST0, bit3 for TEST1).
- R5: With cfg bit0=1 (strict), a memory request is blocked if any bit of addr_taint is set.
- R6: With cfg bit0=0 (permissive), a memory request is blocked only if one of the top GUARD_BITS bits of addr_taint is set.
- R7: A memory step whose benign bit is set (cfg bit4 slot 0, bit5 slot 1, bit6 slot 2) is never blocked, whatever its address taint.
- R8: A blocked request does not raise mem_en in the cycle the violation is detected.
- R9: The cycle after a violation the machine is in HALT (halted=1); it issues no request, control or done pulse and ignores start until reset.
- R10: sec_irq rises together with halted and stays high until irq_clr is pulsed; clearing it does not leave HALT.
- R11: The first violation latches viol_valid=1, viol_state with the step index above and viol_cause (1 branch, 2 address); these hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run from IDLE |
| cfg_we | input | 1 | Write enable of the policy register |
| cfg_wdata | input | 7 | Policy: bit0 strict, bit1 all-branch, bits3:2 critical, bits6:4 benign |
| cmp_result | input | 1 | Comparison result from the datapath |
| cmp_taint | input | 1 | Taint tag of the comparison result |
| addr_taint | input | ADDR_W (16) | Taint vector of the current request address |
| irq_clr | input | 1 | Clears the security interrupt |
| mem_en | output | 1 | Memory request enable |
| mem_we | output | 1 | Memory write (store) |
| mem_slot | output | 2 | Memory operation index (0, 1, 2) |
| alu_add | output | 1 | Add control pulse |
| alu_sub | output | 1 | Subtract control pulse |
| alu_adj | output | 1 | Adjust control pulse |
| done | output | 1 | Run completed |
| busy | output | 1 | Sequence running |
| halted | output | 1 | Machine parked after a violation |
| sec_irq | output | 1 | Security interrupt |
| viol_valid | output | 1 | A violation has been recorded |
| viol_state | output | 4 | Step index of the first violation |
| viol_cause | output | 2 | Cause of the first violation |

## Verification
Runs are made with the comparison true and false, so both branch arms and the extra adjust step are told apart by the sequence of emitted controls. Condition taint is applied under all-branch mode, under a mask that selects only the second branch and under an empty mask, which separates global from per-step checking and shows the halt occurring at the right step. Address taint in a low bit and in a top bit is tried under both protection modes, so the two modes are told apart. Benign marks on some slots and on all slots show that the exemption applies per slot and moves the blocking point to the next unmarked request. After each halt the bench clears the interrupt and pulses start again, which shows that the halt persists and the recorded status is sticky.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

    localparam int NUM_BRANCH = 2;
    localparam int NUM_MEMOP  = 3;
    localparam int BR_IW      = (NUM_BRANCH > 1) ? $clog2(NUM_BRANCH) : 1;
    localparam int MEM_IW     = (NUM_MEMOP > 1) ? $clog2(NUM_MEMOP) : 1;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_FETCH_A = 4'd1,
        ST_FETCH_B = 4'd2,
        ST_TEST0   = 4'd3,
        ST_ADD     = 4'd4,
        ST_SUB     = 4'd5,
        ST_TEST1   = 4'd6,
        ST_ADJUST  = 4'd7,
        ST_STORE   = 4'd8,
        ST_DONE    = 4'd9,
        ST_HALT    = 4'd10
    } step_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_BRANCH = 2'd1,
        CAUSE_ADDR   = 2'd2
    } cause_e;

    typedef struct packed {
        logic [NUM_MEMOP-1:0]  benign;
        logic [NUM_BRANCH-1:0] critical;
        logic                  all_branch;
        logic                  strict;
    } policy_t;

    localparam int CFG_W = $bits(policy_t);

endpackage

// File: rtl/tgc_branch_check.sv
module tgc_branch_check
    import tgc_pkg::*;
#(
    parameter int NB = NUM_BRANCH,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          br_active,
    input  logic [IW-1:0] br_idx,
    input  logic          cond_taint,
    input  logic          all_branch,
    input  logic [NB-1:0] crit_mask,
    output logic          br_viol
);

    logic crit_hit;

    always_comb begin
        crit_hit = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (br_idx == IW'(i)) crit_hit = crit_mask[i];
        end
    end

    assign br_viol = br_active && cond_taint && (all_branch || crit_hit);

endmodule

// File: rtl/tgc_mem_check.sv
module tgc_mem_check
    import tgc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int GUARD_BITS = 4,
    parameter int NM         = NUM_MEMOP,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic              req_active,
    input  logic [IW-1:0]     req_idx,
    input  logic [ADDR_W-1:0] addr_taint,
    input  logic              strict,
    input  logic [NM-1:0]     benign_mask,
    output logic              mem_viol
);

    logic any_taint;
    logic guard_taint;
    logic exempt;

    assign any_taint = |addr_taint;

    generate
        if (GUARD_BITS >= ADDR_W) begin : g_full_guard
            assign guard_taint = any_taint;
        end else begin : g_top_guard
            assign guard_taint = |addr_taint[ADDR_W-1 -: GUARD_BITS];
        end
    endgenerate

    always_comb begin
        exempt = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (req_idx == IW'(i)) exempt = benign_mask[i];
        end
    end

    assign mem_viol = req_active && !exempt && (strict ? any_taint : guard_taint);

endmodule

// File: rtl/tgc_viol_handler.sv
module tgc_viol_handler
    import tgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       br_viol,
    input  logic       mem_viol,
    input  logic [3:0] cur_step,
    input  logic       irq_clr,
    output logic       viol_any,
    output logic       sec_irq,
    output logic       viol_valid,
    output logic [3:0] viol_state,
    output logic [1:0] viol_cause
);

    cause_e cause_now;

    assign viol_any  = br_viol || mem_viol;
    assign cause_now = br_viol ? CAUSE_BRANCH : CAUSE_ADDR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_irq    <= 1'b0;
            viol_valid <= 1'b0;
            viol_state <= 4'd0;
            viol_cause <= CAUSE_NONE;
        end else begin
            if (viol_any && !viol_valid) begin
                viol_valid <= 1'b1;
                viol_state <= cur_step;
                viol_cause <= cause_now;
            end
            if (viol_any) begin
                sec_irq <= 1'b1;
            end else if (irq_clr) begin
                sec_irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/taint_guard_ctrl.sv
module taint_guard_ctrl
    import tgc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int GUARD_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmp_result,
    input  logic              cmp_taint,
    input  logic [ADDR_W-1:0] addr_taint,
    input  logic              irq_clr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_IW-1:0] mem_slot,
    output logic              alu_add,
    output logic              alu_sub,
    output logic              alu_adj,
    output logic              done,
    output logic              busy,
    output logic              halted,
    output logic              sec_irq,
    output logic              viol_valid,
    output logic [3:0]        viol_state,
    output logic [1:0]        viol_cause
);

    step_e              step_q;
    step_e              step_d;
    policy_t            cfg_q;
    logic               br_act;
    logic [BR_IW-1:0]   br_idx;
    logic               mem_act;
    logic [MEM_IW-1:0]  mem_idx;
    logic               br_viol;
    logic               mem_viol;
    logic               viol_any;

    // policy register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{benign: '0, critical: '0, all_branch: 1'b1, strict: 1'b1};
        end else if (cfg_we) begin
            cfg_q <= policy_t'(cfg_wdata);
        end
    end

    // which check applies in the current step
    always_comb begin
        br_act  = 1'b0;
        br_idx  = '0;
        mem_act = 1'b0;
        mem_idx = '0;
        unique case (step_q)
            ST_FETCH_A: begin mem_act = 1'b1; mem_idx = MEM_IW'(0); end
            ST_FETCH_B: begin mem_act = 1'b1; mem_idx = MEM_IW'(1); end
            ST_STORE:   begin mem_act = 1'b1; mem_idx = MEM_IW'(2); end
            ST_TEST0:   begin br_act  = 1'b1; br_idx  = BR_IW'(0);  end
            ST_TEST1:   begin br_act  = 1'b1; br_idx  = BR_IW'(1);  end
            default: ;
        endcase
    end

    tgc_branch_check #(
        .NB(NUM_BRANCH)
    ) i_br_chk (
        .br_active  (br_act),
        .br_idx     (br_idx),
        .cond_taint (cmp_taint),
        .all_branch (cfg_q.all_branch),
        .crit_mask  (cfg_q.critical),
        .br_viol    (br_viol)
    );

    tgc_mem_check #(
        .ADDR_W     (ADDR_W),
        .GUARD_BITS (GUARD_BITS),
        .NM         (NUM_MEMOP)
    ) i_mem_chk (
        .req_active  (mem_act),
        .req_idx     (mem_idx),
        .addr_taint  (addr_taint),
        .strict      (cfg_q.strict),
        .benign_mask (cfg_q.benign),
        .mem_viol    (mem_viol)
    );

    tgc_viol_handler i_handler (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_viol    (br_viol),
        .mem_viol   (mem_viol),
        .cur_step   (step_q),
        .irq_clr    (irq_clr),
        .viol_any   (viol_any),
        .sec_irq    (sec_irq),
        .viol_valid (viol_valid),
        .viol_state (viol_state),
        .viol_cause (viol_cause)
    );

    // next step
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:    if (start) step_d = ST_FETCH_A;
            ST_FETCH_A: step_d = ST_FETCH_B;
            ST_FETCH_B: step_d = ST_TEST0;
            ST_TEST0:   step_d = cmp_result ? ST_ADD : ST_SUB;
            ST_ADD:     step_d = ST_TEST1;
            ST_SUB:     step_d = ST_TEST1;
            ST_TEST1:   step_d = cmp_result ? ST_STORE : ST_ADJUST;
            ST_ADJUST:  step_d = ST_STORE;
            ST_STORE:   step_d = ST_DONE;
            ST_DONE:    step_d = ST_IDLE;
            ST_HALT:    step_d = ST_HALT;
            default:    step_d = ST_HALT;
        endcase
        if (viol_any) step_d = ST_HALT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // outputs
    always_comb begin
        mem_en   = mem_act && !mem_viol;
        mem_we   = mem_en && (step_q == ST_STORE);
        mem_slot = mem_idx;
        alu_add  = (step_q == ST_ADD);
        alu_sub  = (step_q == ST_SUB);
        alu_adj  = (step_q == ST_ADJUST);
        done     = (step_q == ST_DONE);
        busy     = (step_q != ST_IDLE) && (step_q != ST_HALT);
        halted   = (step_q == ST_HALT);
    end

endmodule

// File: rtl/tgc_checker.sv
module tgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_clr,
    input logic       mem_en,
    input logic       mem_we,
    input logic [1:0] mem_slot,
    input logic       alu_add,
    input logic       alu_sub,
    input logic       alu_adj,
    input logic       done,
    input logic       halted,
    input logic       sec_irq,
    input logic       viol_valid,
    input logic [3:0] viol_state,
    input logic [1:0] viol_cause
);

    p_write_on_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && mem_slot == 2'd2));

    p_done_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!halted && !sec_irq && !viol_valid));

    p_issued_not_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !halted);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_en || alu_add || alu_sub || alu_adj || done));

    p_irq_with_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> sec_irq);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_irq && !irq_clr) |=> sec_irq);

    p_status_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |=> (viol_valid && $stable(viol_state) && $stable(viol_cause)));

    p_status_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_cause == 2'd1 || viol_cause == 2'd2));

endmodule

bind taint_guard_ctrl tgc_checker i_tgc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_clr    (irq_clr),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_slot   (mem_slot),
    .alu_add    (alu_add),
    .alu_sub    (alu_sub),
    .alu_adj    (alu_adj),
    .done       (done),
    .halted     (halted),
    .sec_irq    (sec_irq),
    .viol_valid (viol_valid),
    .viol_state (viol_state),
    .viol_cause (viol_cause)
);

// File: tb/test_taint_guard_ctrl.sv
`timescale 1ns/1ps
module test_taint_guard_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        cmp_result = 1'b0;
    logic        cmp_taint = 1'b0;
    logic [15:0] addr_taint = '0;
    logic        irq_clr = 1'b0;
    logic        mem_en, mem_we, alu_add, alu_sub, alu_adj, done, busy, halted;
    logic        sec_irq, viol_valid;
    logic [1:0]  mem_slot, viol_cause;
    logic [3:0]  viol_state;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_q[$];
    string cur_tag  = "R1";
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    taint_guard_ctrl i_taint_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmp_result(cmp_result), .cmp_taint(cmp_taint), .addr_taint(addr_taint),
        .irq_clr(irq_clr), .mem_en(mem_en), .mem_we(mem_we), .mem_slot(mem_slot),
        .alu_add(alu_add), .alu_sub(alu_sub), .alu_adj(alu_adj), .done(done),
        .busy(busy), .halted(halted), .sec_irq(sec_irq), .viol_valid(viol_valid),
        .viol_state(viol_state), .viol_cause(viol_cause)
    );

    task automatic chk(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // event codes: 1/2 reads slot 0/1, 3 write slot 2, 4 add, 5 sub, 6 adj, 7 done
    always @(negedge clk) begin
        if (rst_n) begin
            int code;
            code = 0;
            if (mem_en)       code = (mem_we ? 8 : 0) + int'(mem_slot) + 1;
            else if (alu_add) code = 4;
            else if (alu_sub) code = 5;
            else if (alu_adj) code = 6;
            else if (done)    code = 7;
            if (code == 11) code = 3;
            if (code != 0) begin
                if (exp_q.size() == 0) begin
                    chk({cur_tag, "/R9"}, code, 0, "unexpected event");
                end else begin
                    chk({cur_tag, "/R2"}, code, exp_q.pop_front(), "event order");
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic run_case(string tag, logic [6:0] cfg, bit cmpv, bit ct, logic [15:0] at);
        bit stop_m;
        int e_state;
        int e_cause;
        cur_tag = tag;
        stop_m  = 1'b0;
        e_state = 0;
        e_cause = 0;
        // requirement model: R2 order, R4 branches, R5/R6/R7 requests
        for (int s = 0; s < 7 && !stop_m; s++) begin
            bit mviol;
            bit bviol;
            int slot;
            slot = (s == 0) ? 0 : (s == 1) ? 1 : 2;
            mviol = !cfg[4+slot] && (cfg[0] ? (|at) : (|at[15:12]));
            case (s)
                0, 1: if (mviol) begin stop_m = 1; e_state = s + 1; e_cause = 2; end
                      else exp_q.push_back(s + 1);
                2: begin
                    bviol = ct && (cfg[1] || cfg[2]);
                    if (bviol) begin stop_m = 1; e_state = 3; e_cause = 1; end
                    else exp_q.push_back(cmpv ? 4 : 5);
                end
                3: begin
                    bviol = ct && (cfg[1] || cfg[3]);
                    if (bviol) begin stop_m = 1; e_state = 6; e_cause = 1; end
                    else if (!cmpv) exp_q.push_back(6);
                end
                4: if (mviol) begin stop_m = 1; e_state = 8; e_cause = 2; end
                   else exp_q.push_back(3);
                5: exp_q.push_back(7);
                default: ;
            endcase
        end
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = cfg;
        cmp_result = cmpv; cmp_taint = ct; addr_taint = at;
        @(posedge clk); #1;
        cfg_we = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (12) @(posedge clk);
        #2;
        chk({tag, "/R2"}, exp_q.size(), 0, "missing events");
        chk({tag, "/R9"}, int'(halted), int'(stop_m), "halted");
        chk({tag, "/R10"}, int'(sec_irq), int'(stop_m), "sec_irq");
        chk({tag, "/R11"}, int'(viol_valid), int'(stop_m), "viol_valid");
        chk({tag, "/R11"}, int'(viol_state), e_state, "viol_state");
        chk({tag, "/R11"}, int'(viol_cause), e_cause, "viol_cause");
        if (!stop_m) chk({tag, "/R3"}, int'(busy), 0, "busy after run");
        if (stop_m) begin
            @(posedge clk); #1 irq_clr = 1'b1;
            @(posedge clk); #1 irq_clr = 1'b0;
            chk({tag, "/R10"}, int'(sec_irq), 0, "irq after clear");
            chk({tag, "/R10"}, int'(halted), 1, "halt after clear");
            start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            repeat (4) @(posedge clk);
            #2;
            chk({tag, "/R9"}, int'(halted), 1, "halt after start");
            chk({tag, "/R11"}, int'(viol_state), e_state, "sticky state");
            chk({tag, "/R11"}, int'(viol_cause), e_cause, "sticky cause");
        end
        do_reset();
    endtask

    initial begin
        do_reset();
        #2;
        chk("R1", int'(mem_en), 0, "mem_en at reset");
        chk("R1", int'(busy), 0, "busy at reset");
        chk("R1", int'(halted), 0, "halted at reset");
        chk("R1", int'(sec_irq), 0, "sec_irq at reset");
        chk("R1", int'(viol_valid), 0, "viol_valid at reset");
        chk("R1", int'(done), 0, "done at reset");
        // cfg = {benign[2:0], critical[1:0], all_branch, strict}
        run_case("R2_true",      7'b000_00_11, 1'b1, 1'b0, 16'h0000);
        run_case("R3_false",     7'b000_00_11, 1'b0, 1'b0, 16'h0000);
        run_case("R4_all",       7'b000_00_11, 1'b1, 1'b1, 16'h0000);
        run_case("R4_crit1",     7'b000_10_01, 1'b1, 1'b1, 16'h0000);
        run_case("R4_nocrit",    7'b000_00_01, 1'b0, 1'b1, 16'h0000);
        run_case("R5_strict",    7'b000_00_11, 1'b1, 1'b0, 16'h0001);
        run_case("R8_strictmid", 7'b000_00_11, 1'b0, 1'b0, 16'h0100);
        run_case("R6_lowbit",    7'b000_00_10, 1'b1, 1'b0, 16'h0001);
        run_case("R6_topbit",    7'b000_00_10, 1'b0, 1'b0, 16'h8000);
        run_case("R7_two",       7'b011_00_11, 1'b1, 1'b0, 16'h0001);
        run_case("R7_all",       7'b111_00_10, 1'b0, 1'b0, 16'hF000);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule